// File: doc/BRIEF.md
# Dual-Channel PWM Slice with Gated and Edge Counting

This block is one pulse-width-modulation slice. A single up-counter of `CTR_W` bits is shared by two compare channels, A and B. Each channel drives its output high while the counter sits below that channel's compare value. Each channel can also have its output inverted. A fractional divider sets how fast the counter advances. The divider has an integer part and a sixteenths part. The counter either wraps from the top value back to zero, or it runs up and then down when the centre-aligned option is selected.

The counter has four sources. It can run freely. It can run only while input B is high. It can step on each rising edge of B, or on each falling edge of B. Input B passes through a two-flop synchroniser before any of these modes use it. In the three input modes the B output is held low, because the B pin then serves as an input.

Software writes a new top value and new compare values at any time. The slice takes them into shadow copies only at a wrap, so a period is never cut short. A direct counter write takes effect on the next cycle. One-cycle advance and retard strobes shift the phase by a single count.

Top module: `pwm_slice`

## Requirements
- R1: After reset the counter is 0 and `wrapPulse` is low. With compare inputs of 0 and inversion off, `pwmA` and `pwmB` are low.
- R2: In edge-aligned operation (`phaseCorrect`=0) the counter steps 0,1,…,TOP and then returns to 0. `wrapPulse` is high for the one cycle in which the counter has just returned to 0. Between counter writes, each step changes the counter by at most one or returns it to 0.
- R3: Before inversion, a channel is high exactly while counter < compare. A compare of 0 gives a channel that is always low. A compare above TOP gives a channel that is always high. Over one edge-aligned period of TOP+1 counts, a channel is high for min(compare, TOP+1) counts.
- R4: Setting `invA` or `invB` inverts that channel's output.
- R5: With `phaseCorrect`=1 the counter climbs to TOP and then falls back to 0. The wrap pulse occurs on the return to 0, so a period is 2·TOP counts. Over one period a channel is high for 0 counts if compare is 0, for 2·compare−1 counts if compare is at most TOP, and for 2·TOP counts if compare is above TOP. This holds for TOP ≥ 2.
- R6: The effective division is `divInt` + `divFrac`/16 input cycles per count. A `divInt` of 0 acts as 256. Example: 2.5 with TOP=9 gives exactly 25 cycles per wrap. 1.5 with TOP=1 gives 3 cycles per wrap.
- R7: With `mode`=2'b01 the divider advances only on cycles where the synchronised B is high. At division 1, holding B high for K cycles adds K to the counter.
- R8: With `mode`=2'b10 the divider advances once per rising edge of synchronised B. With `mode`=2'b11 it advances once per falling edge. At division 2, six edges give three counts.
- R9: With `mode`=2'b00 the counter runs freely. In any other mode `pwmB` is low, whatever the values of `cmpB` and `invB`.
- R10: While the slice is enabled, new `topVal`, `cmpA` and `cmpB` values take effect only at the next wrap. While the slice is disabled, the shadow copies follow the inputs.
- R11: A pulse on `ctrWrEn` loads `ctrWrData` into the counter on the next edge and restarts the divider phase. No wrap pulse is raised on that edge.
- R12: One `advStb` pulse inserts one extra count, so with division 4 and TOP=9 that period lasts 36 cycles. One `retStb` pulse swallows the next count, so that period lasts 44 cycles. Both strobes require division greater than 1.
- R13: While `enable` is low and no counter write occurs, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Slice run enable |
| phaseCorrect | input | 1 | 1 = up/down counting, 0 = wrap at TOP |
| mode | input | 2 | 00 free, 01 B-high gated, 10 B rising edge, 11 B falling edge |
| divInt | input | 8 | Divider integer part (0 means 256) |
| divFrac | input | 4 | Divider fraction in sixteenths |
| topVal | input | 16 | Period top value (shadowed) |
| cmpA | input | 16 | Channel A compare (shadowed) |
| cmpB | input | 16 | Channel B compare (shadowed) |
| invA | input | 1 | Invert channel A |
| invB | input | 1 | Invert channel B |
| ctrWrEn | input | 1 | Counter write strobe |
| ctrWrData | input | 16 | Counter write value |
| advStb | input | 1 | Phase advance strobe |
| retStb | input | 1 | Phase retard strobe |
| chanBIn | input | 1 | Asynchronous B input for the counting modes |
| counter | output | 16 | Current counter value |
| pwmA | output | 1 | Channel A output |
| pwmB | output | 1 | Channel B output |
| wrapPulse | output | 1 | One-cycle wrap event |

## Verification
The assertions check on every cycle the properties that hold locally. A wrap always lands on zero, and a step moves the counter by at most one unless it wraps. A disabled slice holds its counter, and a counter write lands on the next cycle. An over-top compare forces channel A high, and B stays low in the input modes. The scenarios alone show the properties that take many cycles to see. These are the duty and period counts in both counting shapes, the exact lengths of fractional-divider periods, gated and edge counts after synchronisation, the deferral of top and compare updates to the next wrap, and the one-count phase shifts.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'b00,
    MODE_LEVEL = 2'b01,
    MODE_RISE  = 2'b10,
    MODE_FALL  = 2'b11
  } cnt_mode_e;

  typedef struct packed {
    logic step;  // advance counter one position in its current direction
    logic load;  // overwrite counter with write data
  } ctr_ctl_t;
endpackage

// File: rtl/pwm_slice_ctrl.sv
module pwm_slice_ctrl
  import pwm_slice_pkg::*;
#(
  parameter int DIV_INT_W  = 8,
  parameter int DIV_FRAC_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  cnt_mode_e             mode,
  input  logic [DIV_INT_W-1:0]  divInt,
  input  logic [DIV_FRAC_W-1:0] divFrac,
  input  logic                  chanBIn,
  input  logic                  advStb,
  input  logic                  retStb,
  input  logic                  ctrWrEn,
  output ctr_ctl_t              ctl
);
  localparam int ACC_W = DIV_INT_W + DIV_FRAC_W + 1;
  localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << DIV_FRAC_W;

  logic bSync1, bSync2, bPrev;
  logic gate, tick, advPend, retPend, issueAdv;
  logic [ACC_W-1:0] acc, accSum, divTotal;

  // zero integer part means maximum division
  assign divTotal = {divInt == '0, divInt, divFrac};
  assign accSum   = acc + ONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bSync1 <= 1'b0;
      bSync2 <= 1'b0;
      bPrev  <= 1'b0;
    end else begin
      bSync1 <= chanBIn;
      bSync2 <= bSync1;
      bPrev  <= bSync2;
    end
  end

  always_comb begin
    unique case (mode)
      MODE_FREE:  gate = 1'b1;
      MODE_LEVEL: gate = bSync2;
      MODE_RISE:  gate = bSync2 & ~bPrev;
      MODE_FALL:  gate = ~bSync2 & bPrev;
      default:    gate = 1'b0;
    endcase
  end

  assign tick     = enable & gate & (accSum >= divTotal);
  assign issueAdv = enable & advPend & ~tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      advPend <= 1'b0;
      retPend <= 1'b0;
    end else begin
      if (ctrWrEn)             acc <= '0;
      else if (enable && gate) acc <= tick ? accSum - divTotal : accSum;

      if (enable && advStb) advPend <= 1'b1;
      else if (issueAdv)    advPend <= 1'b0;

      if (enable && retStb) retPend <= 1'b1;
      else if (tick)        retPend <= 1'b0;
    end
  end

  assign ctl.step = (tick & ~retPend) | issueAdv;
  assign ctl.load = ctrWrEn;
endmodule

// File: rtl/pwm_slice_dp.sv
module pwm_slice_dp
  import pwm_slice_pkg::*;
#(
  parameter int CTR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             phaseCorrect,
  input  cnt_mode_e        mode,
  input  logic [CTR_W-1:0] topVal,
  input  logic [CTR_W-1:0] cmpA,
  input  logic [CTR_W-1:0] cmpB,
  input  logic             invA,
  input  logic             invB,
  input  logic [CTR_W-1:0] ctrWrData,
  input  ctr_ctl_t         ctl,
  output logic [CTR_W-1:0] counter,
  output logic             pwmA,
  output logic             pwmB,
  output logic             wrapPulse,
  output logic [CTR_W-1:0] topS,
  output logic [CTR_W-1:0] ccaS,
  output logic [CTR_W-1:0] ccbS
);
  localparam logic [CTR_W-1:0] ONE = CTR_W'(1);

  logic             downDir, nextDown, wrapNow;
  logic [CTR_W-1:0] nextCtr;

  always_comb begin
    nextCtr  = counter + ONE;
    nextDown = 1'b0;
    wrapNow  = 1'b0;
    if (!phaseCorrect) begin
      if (counter >= topS) begin
        nextCtr = '0;
        wrapNow = 1'b1;
      end
    end else if (!downDir) begin
      if (counter >= topS) begin
        if (topS <= ONE) begin
          nextCtr = '0;
          wrapNow = 1'b1;
        end else begin
          nextCtr  = topS - ONE;
          nextDown = 1'b1;
        end
      end
    end else begin
      if (counter <= ONE) begin
        nextCtr = '0;
        wrapNow = 1'b1;
      end else begin
        nextCtr  = counter - ONE;
        nextDown = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      counter   <= '0;
      downDir   <= 1'b0;
      wrapPulse <= 1'b0;
      topS      <= '0;
      ccaS      <= '0;
      ccbS      <= '0;
    end else begin
      wrapPulse <= 1'b0;
      if (ctl.load) begin
        counter <= ctrWrData;
      end else if (ctl.step) begin
        counter   <= nextCtr;
        downDir   <= nextDown;
        wrapPulse <= wrapNow;
      end
      if (!enable || (ctl.step && wrapNow && !ctl.load)) begin
        topS <= topVal;
        ccaS <= cmpA;
        ccbS <= cmpB;
      end
    end
  end

  assign pwmA = (counter < ccaS) ^ invA;
  assign pwmB = (mode == MODE_FREE) ? ((counter < ccbS) ^ invB) : 1'b0;
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_slice_pkg::*;
#(
  parameter int CTR_W      = 16,
  parameter int DIV_INT_W  = 8,
  parameter int DIV_FRAC_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  phaseCorrect,
  input  logic [1:0]            mode,
  input  logic [DIV_INT_W-1:0]  divInt,
  input  logic [DIV_FRAC_W-1:0] divFrac,
  input  logic [CTR_W-1:0]      topVal,
  input  logic [CTR_W-1:0]      cmpA,
  input  logic [CTR_W-1:0]      cmpB,
  input  logic                  invA,
  input  logic                  invB,
  input  logic                  ctrWrEn,
  input  logic [CTR_W-1:0]      ctrWrData,
  input  logic                  advStb,
  input  logic                  retStb,
  input  logic                  chanBIn,
  output logic [CTR_W-1:0]      counter,
  output logic                  pwmA,
  output logic                  pwmB,
  output logic                  wrapPulse
);
  cnt_mode_e        modeE;
  ctr_ctl_t         ctl;
  logic [CTR_W-1:0] topS, ccaS, ccbS;

  assign modeE = cnt_mode_e'(mode);

  pwm_slice_ctrl #(.DIV_INT_W(DIV_INT_W), .DIV_FRAC_W(DIV_FRAC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(modeE),
    .divInt(divInt), .divFrac(divFrac), .chanBIn(chanBIn),
    .advStb(advStb), .retStb(retStb), .ctrWrEn(ctrWrEn), .ctl(ctl)
  );

  pwm_slice_dp #(.CTR_W(CTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable), .phaseCorrect(phaseCorrect),
    .mode(modeE), .topVal(topVal), .cmpA(cmpA), .cmpB(cmpB),
    .invA(invA), .invB(invB), .ctrWrData(ctrWrData), .ctl(ctl),
    .counter(counter), .pwmA(pwmA), .pwmB(pwmB), .wrapPulse(wrapPulse),
    .topS(topS), .ccaS(ccaS), .ccbS(ccbS)
  );
endmodule

// File: rtl/pwm_slice_chk.sv
module pwm_slice_chk #(
  parameter int CTR_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             ctrWrEn,
  input logic [CTR_W-1:0] ctrWrData,
  input logic [CTR_W-1:0] counter,
  input logic             wrapPulse,
  input logic             pwmA,
  input logic             pwmB,
  input logic             invA,
  input logic [1:0]       mode,
  input logic [CTR_W-1:0] topS,
  input logic [CTR_W-1:0] ccaS
);
  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> counter == '0); // R2

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrWrEn && counter <= topS) |=>
      (counter == $past(counter) || counter == $past(counter) + CTR_W'(1) ||
       counter == $past(counter) - CTR_W'(1) || counter == '0)); // R2

  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    (ccaS > topS && counter <= topS && !invA) |-> pwmA); // R3

  AST_B_IN_INPUT_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'b00) |-> !pwmB); // R9

  AST_CTR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ctrWrEn |=> (counter == $past(ctrWrData) && !wrapPulse)); // R11

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !ctrWrEn) |=> $stable(counter)); // R13
endmodule

bind pwm_slice pwm_slice_chk #(.CTR_W(CTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .ctrWrEn(ctrWrEn),
  .ctrWrData(ctrWrData), .counter(counter), .wrapPulse(wrapPulse),
  .pwmA(pwmA), .pwmB(pwmB), .invA(invA), .mode(mode),
  .topS(topS), .ccaS(ccaS)
);

// File: tb/tb_pwm_slice.sv
`timescale 1ns/1ps
module tb_pwm_slice;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0, phaseCorrect = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [7:0]  divInt = 8'd1;
  logic [3:0]  divFrac = 4'd0;
  logic [15:0] topVal = '0, cmpA = '0, cmpB = '0, ctrWrData = '0;
  logic        invA = 1'b0, invB = 1'b0, ctrWrEn = 1'b0;
  logic        advStb = 1'b0, retStb = 1'b0, chanBIn = 1'b0;
  logic [15:0] counter;
  logic        pwmA, pwmB, wrapPulse;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwm_slice dut (
    .clk(clk), .rstN(rstN), .enable(enable), .phaseCorrect(phaseCorrect),
    .mode(mode), .divInt(divInt), .divFrac(divFrac), .topVal(topVal),
    .cmpA(cmpA), .cmpB(cmpB), .invA(invA), .invB(invB),
    .ctrWrEn(ctrWrEn), .ctrWrData(ctrWrData), .advStb(advStb),
    .retStb(retStb), .chanBIn(chanBIn), .counter(counter),
    .pwmA(pwmA), .pwmB(pwmB), .wrapPulse(wrapPulse)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expFree(int top, int c, bit inv);
    int h = (c > top + 1) ? top + 1 : c;
    return inv ? top + 1 - h : h;
  endfunction

  function automatic int expPc(int top, int c, bit inv);
    int h = (c == 0) ? 0 : (c > top) ? 2 * top : 2 * c - 1;
    return inv ? 2 * top - h : h;
  endfunction

  task automatic setup(input logic [1:0] m, input logic pc, input int di, input int df,
                       input int top, input int ca, input int cb, input logic ia, input logic ib);
    @(negedge clk);
    enable = 1'b0; mode = m; phaseCorrect = pc;
    divInt = 8'(di); divFrac = 4'(df); topVal = 16'(top);
    cmpA = 16'(ca); cmpB = 16'(cb); invA = ia; invB = ib;
    chanBIn = 1'b0; ctrWrEn = 1'b1; ctrWrData = '0;
    @(negedge clk);
    ctrWrEn = 1'b0;
    @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic waitWrap();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!wrapPulse && n < 20000);
    if (n >= 20000) chk("R2 wrap timeout", 0, 1);
  endtask

  task automatic interval(output int n);
    n = 0;
    do begin
      @(negedge clk);
      advStb = 1'b0;
      retStb = 1'b0;
      n++;
    end while (!wrapPulse && n < 20000);
  endtask

  task automatic duty(input string tag, input int p, input int expA, input int expB);
    int hA = 0, hB = 0, w = 0;
    waitWrap();
    for (int i = 0; i < p; i++) begin
      if (i > 0) @(negedge clk);
      hA += int'(pwmA);
      hB += int'(pwmB);
      w  += int'(wrapPulse);
    end
    chk({tag, " chanA high"}, hA, expA);
    chk({tag, " chanB high"}, hB, expB);
    chk({tag, " wraps/period"}, w, 1);
  endtask

  initial begin
    int n, c, top, ca, cb;
    bit ia, ib;
    void'($urandom(32'd5150));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 counter", counter, 0);
    chk("R1 pwmA", pwmA, 0);
    chk("R1 pwmB", pwmB, 0);
    chk("R1 wrap", wrapPulse, 0);

    // directed duty corners, edge-aligned
    setup(2'b00, 1'b0, 1, 0, 20, 0, 21, 1'b0, 1'b0);
    duty("R3 zero/over-top", 21, 0, 21);
    setup(2'b00, 1'b0, 1, 0, 20, 16'hFFFF, 20, 1'b1, 1'b0);
    duty("R4 inverted full", 21, 0, 20);

    // random edge-aligned and phase-correct periods
    for (int it = 0; it < 10; it++) begin
      top = $urandom_range(40, 2);
      ca  = $urandom_range(top + 2, 0);
      cb  = $urandom_range(top + 2, 0);
      ia  = 1'($urandom_range(1, 0));
      ib  = 1'($urandom_range(1, 0));
      if (it % 2 == 0) begin
        setup(2'b00, 1'b0, 1, 0, top, ca, cb, ia, ib);
        duty("R2 R3 R4 edge-aligned", top + 1, expFree(top, ca, ia), expFree(top, cb, ib));
      end else begin
        setup(2'b00, 1'b1, 1, 0, top, ca, cb, ia, ib);
        duty("R5 R4 phase-correct", 2 * top, expPc(top, ca, ia), expPc(top, cb, ib));
      end
    end
    setup(2'b00, 1'b1, 1, 0, 7, 0, 8, 1'b0, 1'b0);
    duty("R5 corners", 14, 0, 14);

    // fractional divider
    setup(2'b00, 1'b0, 2, 8, 9, 0, 0, 1'b0, 1'b0);
    waitWrap();
    interval(n); chk("R6 div 2.5 period", n, 25);
    interval(n); chk("R6 div 2.5 period again", n, 25);
    setup(2'b00, 1'b0, 1, 8, 1, 0, 0, 1'b0, 1'b0);
    waitWrap();
    interval(n); chk("R6 div 1.5 period", n, 3);
    setup(2'b00, 1'b0, 0, 0, 1, 0, 0, 1'b0, 1'b0);
    waitWrap();
    interval(n); chk("R6 div 256 period", n, 512);

    // phase advance / retard
    setup(2'b00, 1'b0, 4, 0, 9, 0, 0, 1'b0, 1'b0);
    waitWrap();
    interval(n); chk("R12 base period", n, 40);
    advStb = 1'b1;
    interval(n); chk("R12 advanced period", n, 36);
    retStb = 1'b1;
    interval(n); chk("R12 retarded period", n, 44);
    interval(n); chk("R12 period restored", n, 40);

    // gated by B level
    setup(2'b01, 1'b0, 1, 0, 16'hFFFE, 0, 100, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 idle while B low", counter, 0);
    chanBIn = 1'b1;
    repeat (7) @(negedge clk);
    chanBIn = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 gated count", counter, 7);
    chk("R9 pwmB low in input mode", pwmB, 0);

    // rising edges
    setup(2'b10, 1'b0, 1, 0, 16'hFFFE, 0, 100, 1'b0, 1'b1);
    for (int k = 0; k < 5; k++) begin
      chanBIn = 1'b1; repeat (3) @(negedge clk);
      chanBIn = 1'b0; repeat (3) @(negedge clk);
    end
    chanBIn = 1'b1; repeat (10) @(negedge clk);
    chk("R8 rising count, long high counts once", counter, 6);
    chk("R9 pwmB low with invB set", pwmB, 0);
    chanBIn = 1'b0; repeat (4) @(negedge clk);
    chk("R8 rising ignores falling", counter, 6);

    // falling edges
    setup(2'b11, 1'b0, 1, 0, 16'hFFFE, 0, 0, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) begin
      chanBIn = 1'b1; repeat (3) @(negedge clk);
      chanBIn = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk("R8 falling count", counter, 5);

    // rising edges through divider 2
    setup(2'b10, 1'b0, 2, 0, 16'hFFFE, 0, 0, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      chanBIn = 1'b1; repeat (3) @(negedge clk);
      chanBIn = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk("R8 rising with divide-by-2", counter, 3);

    // counter write and disabled hold
    setup(2'b00, 1'b0, 1, 0, 16'hFFFE, 0, 0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    ctrWrEn = 1'b1; ctrWrData = 16'h1234;
    @(negedge clk);
    ctrWrEn = 1'b0;
    chk("R11 written value", counter, 16'h1234);
    chk("R11 no wrap on write", wrapPulse, 0);
    @(negedge clk);
    chk("R11 counts on from write", counter, 16'h1235);
    enable = 1'b0;
    c = int'(counter);
    repeat (10) @(negedge clk);
    chk("R13 hold while disabled", counter, c);

    // shadowed top/compare
    setup(2'b00, 1'b0, 1, 0, 99, 20, 0, 1'b0, 1'b0);
    waitWrap();
    while (counter != 16'd50) @(negedge clk);
    cmpA = 16'd80;
    repeat (10) @(negedge clk);
    chk("R10 compare deferred", pwmA, 0);
    topVal = 16'd49;
    interval(n); chk("R10 top deferred", n, 40);
    repeat (10) @(negedge clk);
    chk("R10 compare applied after wrap", pwmA, 1);
    interval(n); chk("R10 new top in effect", n, 40);
    interval(n); chk("R10 new period", n, 50);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule